// File: doc/BRIEF.md
# Multiplexed-Address Cartridge Word Responder

This block is the cartridge side of a parallel bus on which one 16-bit path carries both addresses and data. The host first places the upper half of a 32-bit byte address on the path and pulses the high-half latch strobe. It then does the same for the lower half with the low-half latch strobe. Both strobes are active low. The host then pulses the read strobe or the write strobe repeatedly. Each access moves one 16-bit word to or from an internal word-addressed store, and an internal counter steps to the next word after every access. One address phase therefore serves a whole burst without the address being sent again.

The responder drives the shared path only when three things hold: a read is in progress, no address strobe is active, and the latched address falls inside a parameterised window. At all other times the driver is released. The bus has no wait signal. Read data must be present within a fixed, small number of clock cycles after the read strobe falls.

The bus strobes are asynchronous to the clock. Each one passes through a two-flop synchronizer. The control FSM has four states. S_IDLE means no address is known. S_HALF means the upper half has been latched. S_BURST means accesses are being served. S_SPENT means the burst limit has been reached. Any high-half strobe leads to S_HALF, from any state. Any low-half strobe leads to S_BURST, from any state, and reloads the counter. In S_BURST, the final access of the burst leads to S_SPENT. The store comes out of reset with a fixed image that starts with the header words 0x8037 and 0x1240.

Top module: `cart_bus_responder`

## Requirements
- R1: After reset the FSM is in S_IDLE and a read strobe does not enable the bus driver (`ad_oe` stays 0).
- R2: A fall of `hi_stb_n` latches `ad_in` as byte-address bits 31:16. A later fall of `lo_stb_n` latches bits 15:0 and enters S_BURST. The word index is byte-address bits 8:1, and bit 0 is dropped.
- R3: With power-up contents, a burst from byte address 0x1000_0000 returns 0x8037 on the first read and 0x1240 on the second. Each other word i holds (i*0x0101) XOR 0x5A5A, kept to 16 bits.
- R4: Each rise of `rd_n` or `wr_n` in S_BURST advances the word index by one, modulo 256.
- R5: A write in S_BURST inside the window stores the `ad_in` value held during the low phase of `wr_n` at the current word. A read in a later burst returns that value.
- R6: `ad_oe` is 1 only when `rd_n` is low, both latch strobes are high, the state is S_BURST and byte-address bits 31:9 match the window base (default 0x1000_0000). Out-of-window writes leave the store unchanged.
- R7: After 256 accesses in one burst the FSM enters S_SPENT. From then on reads are not driven and writes are ignored until a new low-half latch.
- R8: A high-half strobe during a burst ends it at once (S_HALF, driver off). The next low-half strobe restarts the burst at the newly latched word.
- R9: `ad_oe` is 1 and `ad_out` is valid by the fourth rising clock edge after `rd_n` falls. `ad_oe` is 0 by the fourth rising edge after `rd_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ad_in | input | 16 | Shared address/data path, input side |
| hi_stb_n | input | 1 | Active-low latch strobe for address bits 31:16 |
| lo_stb_n | input | 1 | Active-low latch strobe for address bits 15:0 |
| rd_n | input | 1 | Active-low read strobe (output enable) |
| wr_n | input | 1 | Active-low write strobe (write enable) |
| ad_out | output | 16 | Read data onto the shared path |
| ad_oe | output | 1 | Tristate enable for `ad_out` |

## Verification
A strobe edge reaches the synchronized level two edges after the pin changes, so `ad_oe` follows `rd_n` within three edges. An access rise moves the index one edge after the synchronized rise, and the registered read word follows one edge after that. The bench always waits at least four edges after each strobe change before it samples at a falling clock edge, and it waits six edges between accesses. Each access pushes its expected enable and data into a queue. A monitor process pops the entry at the agreed sample point.

// File: rtl/cart_pkg.sv
package cart_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_HALF  = 2'd1,
        S_BURST = 2'd2,
        S_SPENT = 2'd3
    } bus_state_t;

    // power-up image: two header words, then a computed pattern
    function automatic logic [15:0] image_word(input int unsigned i);
        logic [15:0] v;
        if (i == 0)      v = 16'h8037;
        else if (i == 1) v = 16'h1240;
        else             v = 16'((i * 32'h0101) ^ 32'h5A5A);
        return v;
    endfunction

endpackage

// File: rtl/cart_sync.sv
module cart_sync #(
    parameter int  WIDTH = 2,
    parameter bit  RISE  = 1'b1   // 1: pulse on rise, 0: pulse on fall
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] pulse
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic s1, s2, s3;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b1;
                s2 <= 1'b1;
                s3 <= 1'b1;
            end else begin
                s1 <= raw[g];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign lvl[g] = s2;
        if (RISE) begin : g_rise
            assign pulse[g] = s2 & ~s3;
        end else begin : g_fall
            assign pulse[g] = ~s2 & s3;
        end
    end
endmodule

// File: rtl/cart_ctrl.sv
module cart_ctrl
    import cart_pkg::*;
#(
    parameter int          MEM_AW      = 8,
    parameter int          BURST_WORDS = 256,
    parameter logic [31:0] WIN_BASE    = 32'h1000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_fall,
    input  logic              lo_fall,
    input  logic              acc_rise,
    input  logic [15:0]       hi_bits,
    input  logic [15:1]       lo_bits,
    output bus_state_t        state,
    output logic [MEM_AW-1:0] idx,
    output logic              in_win
);
    localparam int BW    = $clog2(BURST_WORDS + 1);
    localparam int LO_HI = MEM_AW + 1;

    bus_state_t   nxt;
    logic [15:0]  hi_q;
    logic [15:LO_HI] lo_top_q;
    logic [BW-1:0] beats;
    logic [31:0]  addr_view;

    assign addr_view = {hi_q, lo_top_q, {LO_HI{1'b0}}};
    assign in_win    = (addr_view[31:LO_HI] == WIN_BASE[31:LO_HI]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next-state decision
    always_comb begin
        nxt = state;
        if (hi_fall) begin
            nxt = S_HALF;
        end else if (lo_fall) begin
            nxt = S_BURST;
        end else begin
            unique case (state)
                S_IDLE:  nxt = S_IDLE;
                S_HALF:  nxt = S_HALF;
                S_BURST: if (acc_rise && beats == BW'(BURST_WORDS - 1)) nxt = S_SPENT;
                S_SPENT: nxt = S_SPENT;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // address latches and burst counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q     <= '0;
            lo_top_q <= '0;
            idx      <= '0;
            beats    <= '0;
        end else begin
            if (hi_fall) hi_q <= hi_bits;
            if (lo_fall) begin
                lo_top_q <= lo_bits[15:LO_HI];
                idx      <= lo_bits[MEM_AW:1];
                beats    <= '0;
            end else if (acc_rise && state == S_BURST && !hi_fall) begin
                idx   <= idx + 1'b1;
                beats <= beats + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cart_mem.sv
module cart_mem
    import cart_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MEM_AW-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [15:0] store [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= image_word(i);
            rdata <= '0;
        end else begin
            if (we) store[addr] <= wdata;
            rdata <= store[addr];
        end
    end
endmodule

// File: rtl/cart_bus_responder.sv
module cart_bus_responder
    import cart_pkg::*;
#(
    parameter int          MEM_AW      = 8,
    parameter int          BURST_WORDS = 256,
    parameter logic [31:0] WIN_BASE    = 32'h1000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] ad_in,
    input  logic        hi_stb_n,
    input  logic        lo_stb_n,
    input  logic        rd_n,
    input  logic        wr_n,
    output logic [15:0] ad_out,
    output logic        ad_oe
);
    logic [1:0] lat_lvl, lat_fall;
    logic [1:0] acc_lvl, acc_rise_v;
    logic       hi_fall, lo_fall, rd_lvl, wr_lvl, acc_rise;
    logic       in_win, we;
    logic [MEM_AW-1:0] idx;
    logic [15:0] wcap, rdata;
    bus_state_t  state;

    cart_sync #(.WIDTH(2), .RISE(1'b0)) u_lat_sync (
        .clk(clk), .rst_n(rst_n), .raw({lo_stb_n, hi_stb_n}),
        .lvl(lat_lvl), .pulse(lat_fall)
    );

    cart_sync #(.WIDTH(2), .RISE(1'b1)) u_acc_sync (
        .clk(clk), .rst_n(rst_n), .raw({wr_n, rd_n}),
        .lvl(acc_lvl), .pulse(acc_rise_v)
    );

    assign hi_fall  = lat_fall[0];
    assign lo_fall  = lat_fall[1];
    assign rd_lvl   = acc_lvl[0];
    assign wr_lvl   = acc_lvl[1];
    assign acc_rise = |acc_rise_v;

    cart_ctrl #(.MEM_AW(MEM_AW), .BURST_WORDS(BURST_WORDS), .WIN_BASE(WIN_BASE)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .hi_fall(hi_fall), .lo_fall(lo_fall), .acc_rise(acc_rise),
        .hi_bits(ad_in), .lo_bits(ad_in[15:1]),
        .state(state), .idx(idx), .in_win(in_win)
    );

    // hold write data while the synchronized write strobe is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wcap <= '0;
        else if (!wr_lvl) wcap <= ad_in;
    end

    assign we = acc_rise_v[1] && state == S_BURST && in_win && !hi_fall && !lo_fall;

    cart_mem #(.MEM_AW(MEM_AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(idx),
        .wdata(wcap), .rdata(rdata)
    );

    // output process
    always_comb begin
        ad_out = rdata;
        ad_oe  = !rd_lvl && (&lat_lvl) && state == S_BURST && in_win;
    end
endmodule

// File: rtl/cart_chk.sv
module cart_chk
    import cart_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input bus_state_t        state,
    input logic              ad_oe,
    input logic              rd_lvl,
    input logic              hi_fall,
    input logic              lo_fall,
    input logic              acc_rise,
    input logic [MEM_AW-1:0] idx
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !ad_oe);

    // R6
    oe_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!rd_lvl && state == S_BURST));

    // R2
    lo_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_fall && !hi_fall) |=> (state == S_BURST));

    // R4
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rise && state == S_BURST && !hi_fall && !lo_fall) |=> (idx == $past(idx) + 1'b1));

    // R7
    spent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SPENT) |-> !ad_oe);

    // R8
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_fall |=> (state == S_HALF && !ad_oe));
endmodule

bind cart_bus_responder cart_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .ad_oe(ad_oe), .rd_lvl(rd_lvl),
    .hi_fall(hi_fall), .lo_fall(lo_fall), .acc_rise(acc_rise), .idx(idx)
);

// File: tb/sim_cart_bus_responder.sv
`timescale 1ns/1ps
module sim_cart_bus_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ad_in = '0;
    logic        hi_stb_n = 1'b1, lo_stb_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] ad_out;
    logic        ad_oe;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [15:0] model [256];
    logic [16:0] q_exp [$];
    string       q_tag [$];
    event        sample_ev;

    always #2 clk = ~clk;

    cart_bus_responder u0 (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .hi_stb_n(hi_stb_n),
        .lo_stb_n(lo_stb_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe)
    );

    function automatic logic [15:0] pattern(input int i);
        if (i == 0) return 16'h8037;
        if (i == 1) return 16'h1240;
        return 16'((i * 257) ^ 16'h5A5A);
    endfunction

    // monitor: pops one expectation per sample event
    initial begin
        forever begin
            @(sample_ev);
            @(negedge clk);
            begin
                logic [16:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                vectors++;
                if (ad_oe !== e[16] || (e[16] && ad_out !== e[15:0])) begin
                    errors++;
                    $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h",
                             t, ad_oe, ad_out, e[16], e[15:0]);
                end
            end
        end
    end

    task automatic latch_hi(input logic [15:0] v);
        @(negedge clk); ad_in = v; hi_stb_n = 1'b0;
        repeat (4) @(negedge clk); hi_stb_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic latch_lo(input logic [15:0] v);
        @(negedge clk); ad_in = v; lo_stb_n = 1'b0;
        repeat (4) @(negedge clk); lo_stb_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read(input bit oe, input logic [15:0] d, input string tag);
        @(negedge clk); rd_n = 1'b0;
        repeat (4) @(posedge clk);
        q_exp.push_back({oe, d}); q_tag.push_back(tag);
        -> sample_ev;
        repeat (2) @(negedge clk);
        rd_n = 1'b1;
        repeat (4) @(posedge clk);
        q_exp.push_back({1'b0, 16'h0}); q_tag.push_back("R9 release");
        -> sample_ev;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_write(input logic [15:0] d);
        @(negedge clk); ad_in = d; wr_n = 1'b0;
        repeat (5) @(negedge clk); wr_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = pattern(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: no address phase yet
        do_read(1'b0, 16'h0, "R1 reset idle");

        // R2 R3 R4 R7: full burst from window base
        latch_hi(16'h1000);
        latch_lo(16'h0000);
        for (int i = 0; i < 256; i++)
            do_read(1'b1, model[i], i < 2 ? "R3 header" : "R4 R7 burst word");
        do_read(1'b0, 16'h0, "R7 spent read");
        do_write(16'hDEAD);              // R7 ignored in S_SPENT
        latch_lo(16'h0000);
        do_read(1'b1, model[0], "R7 write ignored after limit");

        // R2: mid-window start, bit 0 dropped
        latch_lo(16'h0041);
        do_read(1'b1, model[32], "R2 word 0x20");
        do_read(1'b1, model[33], "R4 next word");

        // R5: writes then readback
        latch_lo(16'h0020);
        do_write(16'hA5C3); model[16] = 16'hA5C3;
        do_write(16'h0F0F); model[17] = 16'h0F0F;
        latch_lo(16'h0020);
        do_read(1'b1, model[16], "R5 readback 0");
        do_read(1'b1, model[17], "R5 readback 1");

        // R4 wrap at top of store
        latch_lo(16'h01FE);
        do_read(1'b1, model[255], "R4 last word");
        do_read(1'b1, model[0], "R4 wrap");

        // R6: out of window
        latch_hi(16'h2000);
        latch_lo(16'h0000);
        do_read(1'b0, 16'h0, "R6 outside window");
        do_write(16'hBEEF);
        latch_hi(16'h1000);
        latch_lo(16'h0000);
        do_read(1'b1, model[0], "R6 write outside ignored");

        // R8: cancel mid-burst
        latch_lo(16'h0010);
        do_read(1'b1, model[8], "R8 before cancel");
        latch_hi(16'h1000);
        do_read(1'b0, 16'h0, "R8 cancelled");
        latch_lo(16'h0064);
        do_read(1'b1, model[50], "R8 restart");

        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule